// File: doc/BRIEF.md
# Power Delivery Receive Filter and Acknowledge Header Builder

This block looks at every Power Delivery message that the receiver has finished decoding. At the end-of-message strobe it takes in the start-of-packet kind, the 16-bit message header and the receive-error flag. It then decides one of three things. The message may go up to the protocol layer. It may be an acknowledgement from the partner, which is reported together with its message ID. Or it may be dropped. For each message that must be answered, the block also builds the 16-bit header of the acknowledgement (GoodCRC) reply and says which start-of-packet kind the reply must use.

The block is a small state machine. The state register holds the verdict for the message that has just ended. The output process turns the current state into one-cycle strobes. The states are ST_IDLE (no message pending), ST_FWD_ACK (forward and acknowledge), ST_ACK_ONLY (acknowledge, but keep the message from the protocol layer), ST_GOT_ACK (a partner acknowledgement arrived) and ST_DROP (the message is discarded with no effect). Every cycle with the end-of-message strobe moves the machine from its current state into the verdict state for that message. Every other cycle returns it to ST_IDLE.

The reply is always two bytes long, the header alone. Storing the payload and checking the CRC are done elsewhere.

Top module: `pd_rx_ack`

## Requirements
- R1: After reset, and while reset is held, the outputs fwd_o, ackrx_o and ackreq_o are low.
- R2: A header counts as an acknowledgement only when all three of these hold: its message type (bits 4:0) equals GOODCRC_CODE (default 1), its data-object count (bits 14:12) is 0, and its extended bit (bit 15) is 0. A header with the acknowledgement type code but a non-zero count, or with bit 15 set, is treated as an ordinary message.
- R3: An error-free acknowledgement raises ackrx_o, with ackrx_id_o set to its bits 11:9. This happens whatever the packet kind is and whatever prime_en_i is. Such a message never raises fwd_o or ackreq_o.
- R4: An error-free ordinary message is accepted when its packet kind equals SOP_CODE (default 0), or when prime_en_i is high. An accepted message raises ackreq_o, and raises fwd_o unless BIST mode is active. An ordinary message that is not accepted raises no output.
- R5: ackreq_type_o equals the packet kind of the message being answered. Kind codes: 0 SOP, 1 SOP', 2 SOP'', 3 SOP' debug, 4 SOP'' debug.
- R6: ackreq_hdr_o copies the message ID (bits 11:9) and the spec revision (bits 7:6) from the received header. Its bits 4:0 are GOODCRC_CODE, and bits 15:12 are 0.
- R7: In ackreq_hdr_o, bit 8 is pwr_role_i and bit 5 is data_role_i, both taken at end-of-message, but only when the packet kind is SOP. For every other kind both bits are 0.
- R8: When bist_i is high at end-of-message, an accepted message raises ackreq_o and does not raise fwd_o.
- R9: A message whose end-of-message strobe comes with rx_err_i high raises none of fwd_o, ackrx_o or ackreq_o, even when it is an acknowledgement.
- R10: Each strobe is high for exactly the one cycle after the clock edge that sampled eom_i high. End-of-message strobes on consecutive cycles each give their own result.
- R11: While eom_i is low, changes on the other inputs raise no output strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eom_i | input | 1 | End-of-message strobe; qualifies all other message inputs |
| rx_err_i | input | 1 | Message ended with a receive error |
| pkt_type_i | input | 3 | Start-of-packet kind of the message |
| hdr_i | input | 16 | Received message header |
| pwr_role_i | input | 1 | Local power role bit used in SOP replies |
| data_role_i | input | 1 | Local data role bit used in SOP replies |
| prime_en_i | input | 1 | Accept packet kinds other than SOP |
| bist_i | input | 1 | BIST mode: acknowledge but do not forward |
| fwd_o | output | 1 | Forward strobe toward the protocol layer |
| ackrx_o | output | 1 | Partner acknowledgement received |
| ackrx_id_o | output | 3 | Message ID of the received acknowledgement |
| ackreq_o | output | 1 | Request to send an acknowledgement reply |
| ackreq_hdr_o | output | 16 | Header of the reply |
| ackreq_type_o | output | 3 | Packet kind for the reply |

## Verification
The corner that is hardest to reach is a set of conditions that overlap within one end-of-message cycle. Examples: an acknowledgement that comes on a non-SOP kind with prime reception off, an acknowledgement that also carries an error, and near-miss headers that have the acknowledgement type code but a non-zero count or the extended bit set. A driver task sets up each of these cases as one strobe with chosen field values, and a reference function computes the expected verdict. A second strobe on the very next cycle makes sure that the state moves straight from one verdict to the next without passing through ST_IDLE.

// File: rtl/pd_rx_ack_pkg.sv
package pd_rx_ack_pkg;

    localparam int ID_W   = 3;
    localparam int REV_W  = 2;
    localparam int CNT_W  = 3;
    localparam int MT_W   = 5;
    localparam int KIND_W = 3;
    localparam int HDR_W  = 1 + CNT_W + ID_W + 1 + REV_W + 1 + MT_W;

    typedef struct packed {
        logic              ext;
        logic [CNT_W-1:0]  ndo;
        logic [ID_W-1:0]   id;
        logic              prole;
        logic [REV_W-1:0]  rev;
        logic              drole;
        logic [MT_W-1:0]   mtype;
    } pd_hdr_t;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_FWD_ACK  = 3'd1,
        ST_ACK_ONLY = 3'd2,
        ST_GOT_ACK  = 3'd3,
        ST_DROP     = 3'd4
    } rx_state_e;

endpackage

// File: rtl/pd_rx_classify.sv
module pd_rx_classify
    import pd_rx_ack_pkg::*;
#(
    parameter logic [MT_W-1:0]   GOODCRC_CODE = 5'd1,
    parameter logic [KIND_W-1:0] SOP_CODE     = 3'd0
) (
    input  logic              ext_i,
    input  logic [CNT_W-1:0]  ndo_i,
    input  logic [MT_W-1:0]   mtype_i,
    input  logic [KIND_W-1:0] kind_i,
    input  logic              err_i,
    input  logic              prime_en_i,
    input  logic              bist_i,
    output rx_state_e         verdict_o
);

    logic is_ack;
    logic accepted;

    always_comb begin
        is_ack   = (ndo_i == '0) && !ext_i && (mtype_i == GOODCRC_CODE);
        accepted = (kind_i == SOP_CODE) || prime_en_i;
        if (err_i) begin
            verdict_o = ST_DROP;
        end else if (is_ack) begin
            verdict_o = ST_GOT_ACK;
        end else if (accepted) begin
            verdict_o = bist_i ? ST_ACK_ONLY : ST_FWD_ACK;
        end else begin
            verdict_o = ST_DROP;
        end
    end

endmodule

// File: rtl/pd_ack_hdr_build.sv
module pd_ack_hdr_build
    import pd_rx_ack_pkg::*;
#(
    parameter logic [MT_W-1:0]   GOODCRC_CODE = 5'd1,
    parameter logic [KIND_W-1:0] SOP_CODE     = 3'd0
) (
    input  logic [ID_W-1:0]   id_i,
    input  logic [REV_W-1:0]  rev_i,
    input  logic [KIND_W-1:0] kind_i,
    input  logic              prole_i,
    input  logic              drole_i,
    output logic [HDR_W-1:0]  hdr_o
);

    pd_hdr_t reply;
    logic    on_sop;

    always_comb begin
        on_sop      = (kind_i == SOP_CODE);
        reply.ext   = 1'b0;
        reply.ndo   = '0;
        reply.id    = id_i;
        reply.prole = on_sop ? prole_i : 1'b0;
        reply.rev   = rev_i;
        reply.drole = on_sop ? drole_i : 1'b0;
        reply.mtype = GOODCRC_CODE;
        hdr_o       = reply;
    end

endmodule

// File: rtl/pd_rx_fsm.sv
module pd_rx_fsm
    import pd_rx_ack_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eom_i,
    input  logic              err_i,
    input  logic              bist_i,
    input  rx_state_e         verdict_i,
    input  logic [ID_W-1:0]   id_i,
    input  logic [REV_W-1:0]  rev_i,
    input  logic [KIND_W-1:0] kind_i,
    input  logic              prole_i,
    input  logic              drole_i,
    output logic [ID_W-1:0]   id_q,
    output logic [REV_W-1:0]  rev_q,
    output logic [KIND_W-1:0] kind_q,
    output logic              prole_q,
    output logic              drole_q,
    output logic              fwd_o,
    output logic              ackrx_o,
    output logic              ackreq_o
);

    rx_state_e state;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= eom_i ? verdict_i : ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q    <= '0;
            rev_q   <= '0;
            kind_q  <= '0;
            prole_q <= 1'b0;
            drole_q <= 1'b0;
        end else if (eom_i) begin
            id_q    <= id_i;
            rev_q   <= rev_i;
            kind_q  <= kind_i;
            prole_q <= prole_i;
            drole_q <= drole_i;
        end
    end

    always_comb begin
        fwd_o    = 1'b0;
        ackrx_o  = 1'b0;
        ackreq_o = 1'b0;
        unique case (state)
            ST_IDLE:     ;
            ST_DROP:     ;
            ST_FWD_ACK:  begin fwd_o = 1'b1; ackreq_o = 1'b1; end
            ST_ACK_ONLY: ackreq_o = 1'b1;
            ST_GOT_ACK:  ackrx_o = 1'b1;
            default:     ;
        endcase
    end

    AST_STROBE_NEEDS_EOM: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(eom_i) |-> !(fwd_o || ackrx_o || ackreq_o)); // R10
    AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(eom_i && err_i) |-> !(fwd_o || ackrx_o || ackreq_o)); // R9
    AST_BIST_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(eom_i && bist_i) |-> !fwd_o); // R8
    AST_FWD_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_o |-> ackreq_o); // R4
    AST_ACKRX_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        ackrx_o |-> !(ackreq_o || fwd_o)); // R3

endmodule

// File: rtl/pd_rx_ack.sv
module pd_rx_ack
    import pd_rx_ack_pkg::*;
#(
    parameter logic [MT_W-1:0]   GOODCRC_CODE = 5'd1,
    parameter logic [KIND_W-1:0] SOP_CODE     = 3'd0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eom_i,
    input  logic              rx_err_i,
    input  logic [KIND_W-1:0] pkt_type_i,
    input  logic [HDR_W-1:0]  hdr_i,
    input  logic              pwr_role_i,
    input  logic              data_role_i,
    input  logic              prime_en_i,
    input  logic              bist_i,
    output logic              fwd_o,
    output logic              ackrx_o,
    output logic [ID_W-1:0]   ackrx_id_o,
    output logic              ackreq_o,
    output logic [HDR_W-1:0]  ackreq_hdr_o,
    output logic [KIND_W-1:0] ackreq_type_o
);

    pd_hdr_t           rx_hdr;
    rx_state_e         verdict;
    logic [ID_W-1:0]   id_q;
    logic [REV_W-1:0]  rev_q;
    logic [KIND_W-1:0] kind_q;
    logic              prole_q;
    logic              drole_q;

    assign rx_hdr = hdr_i;

    pd_rx_classify #(
        .GOODCRC_CODE (GOODCRC_CODE),
        .SOP_CODE     (SOP_CODE)
    ) u_classify (
        .ext_i      (rx_hdr.ext),
        .ndo_i      (rx_hdr.ndo),
        .mtype_i    (rx_hdr.mtype),
        .kind_i     (pkt_type_i),
        .err_i      (rx_err_i),
        .prime_en_i (prime_en_i),
        .bist_i     (bist_i),
        .verdict_o  (verdict)
    );

    pd_rx_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .eom_i     (eom_i),
        .err_i     (rx_err_i),
        .bist_i    (bist_i),
        .verdict_i (verdict),
        .id_i      (rx_hdr.id),
        .rev_i     (rx_hdr.rev),
        .kind_i    (pkt_type_i),
        .prole_i   (pwr_role_i),
        .drole_i   (data_role_i),
        .id_q      (id_q),
        .rev_q     (rev_q),
        .kind_q    (kind_q),
        .prole_q   (prole_q),
        .drole_q   (drole_q),
        .fwd_o     (fwd_o),
        .ackrx_o   (ackrx_o),
        .ackreq_o  (ackreq_o)
    );

    pd_ack_hdr_build #(
        .GOODCRC_CODE (GOODCRC_CODE),
        .SOP_CODE     (SOP_CODE)
    ) u_build (
        .id_i    (id_q),
        .rev_i   (rev_q),
        .kind_i  (kind_q),
        .prole_i (prole_q),
        .drole_i (drole_q),
        .hdr_o   (ackreq_hdr_o)
    );

    assign ackrx_id_o    = id_q;
    assign ackreq_type_o = kind_q;

    AST_REPLY_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        ackreq_o |-> ackreq_type_o == $past(pkt_type_i)); // R5
    AST_REPLY_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        ackreq_o |-> (ackreq_hdr_o[11:9] == $past(hdr_i[11:9]))
                  && (ackreq_hdr_o[7:6] == $past(hdr_i[7:6]))); // R6
    AST_REPLY_ROLES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ackreq_o && ackreq_type_o != SOP_CODE) |->
            !ackreq_hdr_o[8] && !ackreq_hdr_o[5]); // R7
    AST_ACK_ID_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        ackrx_o |-> ackrx_id_o == $past(hdr_i[11:9])); // R3

endmodule

// File: tb/pd_rx_ack_test.sv
module pd_rx_ack_test;

    typedef struct {
        logic        fwd;
        logic        ackrx;
        logic [2:0]  id;
        logic        ackreq;
        logic [15:0] hdr;
        logic [2:0]  kind;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        eom_i = 1'b0;
    logic        rx_err_i = 1'b0;
    logic [2:0]  pkt_type_i = '0;
    logic [15:0] hdr_i = '0;
    logic        pwr_role_i = 1'b0;
    logic        data_role_i = 1'b0;
    logic        prime_en_i = 1'b0;
    logic        bist_i = 1'b0;
    logic        fwd_o, ackrx_o, ackreq_o;
    logic [2:0]  ackrx_id_o, ackreq_type_o;
    logic [15:0] ackreq_hdr_o;

    int errors = 0;
    int checks = 0;
    bit finished = 0;
    exp_t q[$];

    always #10 clk = ~clk;

    pd_rx_ack uut (
        .clk(clk), .rst_n(rst_n), .eom_i(eom_i), .rx_err_i(rx_err_i),
        .pkt_type_i(pkt_type_i), .hdr_i(hdr_i), .pwr_role_i(pwr_role_i),
        .data_role_i(data_role_i), .prime_en_i(prime_en_i), .bist_i(bist_i),
        .fwd_o(fwd_o), .ackrx_o(ackrx_o), .ackrx_id_o(ackrx_id_o),
        .ackreq_o(ackreq_o), .ackreq_hdr_o(ackreq_hdr_o),
        .ackreq_type_o(ackreq_type_o)
    );

    function automatic logic [15:0] mk_hdr(logic ext, logic [2:0] cnt, logic [2:0] id,
                                           logic pr, logic [1:0] rev, logic dr,
                                           logic [4:0] mt);
        return {ext, cnt, id, pr, rev, dr, mt};
    endfunction

    function automatic exp_t model(logic [2:0] kind, logic [15:0] h, logic err,
                                   logic pr, logic dr, logic prime, logic bist,
                                   string tag);
        exp_t e;
        logic ack_msg;
        e = '{1'b0, 1'b0, 3'd0, 1'b0, 16'd0, 3'd0, tag};
        ack_msg = (h[4:0] == 5'd1) && (h[14:12] == 3'd0) && !h[15];
        if (!err) begin
            if (ack_msg) begin
                e.ackrx = 1'b1;
                e.id    = h[11:9];
            end else if (kind == 3'd0 || prime) begin
                e.ackreq = 1'b1;
                e.fwd    = !bist;
                e.kind   = kind;
                e.hdr    = mk_hdr(1'b0, 3'd0, h[11:9], (kind == 3'd0) ? pr : 1'b0,
                                  h[7:6], (kind == 3'd0) ? dr : 1'b0, 5'd1);
            end
        end
        return e;
    endfunction

    task automatic send(logic [2:0] kind, logic [15:0] h, logic err, logic pr,
                        logic dr, logic prime, logic bist, string tag);
        @(negedge clk);
        eom_i = 1'b1; pkt_type_i = kind; hdr_i = h; rx_err_i = err;
        pwr_role_i = pr; data_role_i = dr; prime_en_i = prime; bist_i = bist;
        q.push_back(model(kind, h, err, pr, dr, prime, bist, tag));
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            eom_i = 1'b0;
        end
    endtask

    task automatic noise(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            eom_i = 1'b0; rx_err_i = i[0]; pkt_type_i = 3'(i);
            hdr_i = 16'(16'h1201 + i * 16'h0731); prime_en_i = 1'b1;
            pwr_role_i = 1'b1; data_role_i = 1'b1;
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        #5;
        if (rst_n && !finished) begin
            exp_t e;
            bit bad;
            if (q.size() > 0) e = q.pop_front();
            else e = '{1'b0, 1'b0, 3'd0, 1'b0, 16'd0, 3'd0, "R11 R10 idle"};
            bad = (fwd_o !== e.fwd) || (ackrx_o !== e.ackrx) || (ackreq_o !== e.ackreq);
            if (e.ackrx && ackrx_id_o !== e.id) bad = 1;
            if (e.ackreq && (ackreq_hdr_o !== e.hdr || ackreq_type_o !== e.kind)) bad = 1;
            checks++;
            if (bad) begin
                errors++;
                $display("FAIL %s: got fwd=%b ackrx=%b id=%0d ackreq=%b hdr=%h kind=%0d; exp fwd=%b ackrx=%b id=%0d ackreq=%b hdr=%h kind=%0d",
                         e.tag, fwd_o, ackrx_o, ackrx_id_o, ackreq_o, ackreq_hdr_o,
                         ackreq_type_o, e.fwd, e.ackrx, e.id, e.ackreq, e.hdr, e.kind);
            end
        end
    end

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: got hung run, exp completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if ({fwd_o, ackrx_o, ackreq_o} !== 3'b000) begin
            errors++;
            $display("FAIL R1: got %b exp 000 during reset", {fwd_o, ackrx_o, ackreq_o});
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if ({fwd_o, ackrx_o, ackreq_o} !== 3'b000) begin
            errors++;
            $display("FAIL R1: got %b exp 000 after reset", {fwd_o, ackrx_o, ackreq_o});
        end
        idle(2);
        // R4 R6 R7: SOP data message, roles set
        send(3'd0, mk_hdr(0, 3'd2, 3'd5, 0, 2'd2, 0, 5'd2), 0, 1, 1, 0, 0, "R4 R6 R7 sop");
        idle(1);
        // R7: SOP with roles low, other revision
        send(3'd0, mk_hdr(0, 3'd0, 3'd7, 1, 2'd1, 1, 5'd3), 0, 0, 0, 0, 0, "R7 sop roles0");
        idle(1);
        // R4: SOP' rejected with prime disabled
        send(3'd1, mk_hdr(0, 3'd1, 3'd2, 0, 2'd2, 0, 5'd4), 0, 1, 1, 0, 0, "R4 prime off");
        idle(1);
        // R5 R7: SOP' accepted, roles forced to zero
        send(3'd1, mk_hdr(0, 3'd1, 3'd2, 0, 2'd2, 0, 5'd4), 0, 1, 1, 1, 0, "R5 R7 prime");
        idle(1);
        send(3'd4, mk_hdr(0, 3'd0, 3'd6, 0, 2'd0, 0, 5'd15), 0, 1, 1, 1, 0, "R5 R6 dbg2");
        idle(1);
        // R3: acknowledgement on SOP and on SOP'' with prime off
        send(3'd0, mk_hdr(0, 3'd0, 3'd3, 1, 2'd2, 1, 5'd1), 0, 1, 1, 0, 0, "R3 ack sop");
        idle(1);
        send(3'd2, mk_hdr(0, 3'd0, 3'd6, 0, 2'd1, 0, 5'd1), 0, 0, 0, 0, 0, "R3 ack prime off");
        idle(1);
        // R2: near misses
        send(3'd0, mk_hdr(0, 3'd1, 3'd4, 0, 2'd2, 0, 5'd1), 0, 1, 0, 0, 0, "R2 count nonzero");
        idle(1);
        send(3'd0, mk_hdr(1, 3'd0, 3'd1, 0, 2'd2, 0, 5'd1), 0, 0, 1, 0, 0, "R2 ext set");
        idle(1);
        // R8: BIST
        send(3'd0, mk_hdr(0, 3'd7, 3'd2, 0, 2'd2, 0, 5'd3), 0, 1, 1, 0, 1, "R8 bist");
        idle(1);
        send(3'd0, mk_hdr(0, 3'd0, 3'd5, 0, 2'd2, 0, 5'd1), 0, 1, 1, 0, 1, "R8 R3 bist ack");
        idle(1);
        // R9: errors
        send(3'd0, mk_hdr(0, 3'd2, 3'd5, 0, 2'd2, 0, 5'd2), 1, 1, 1, 1, 0, "R9 err msg");
        idle(1);
        send(3'd0, mk_hdr(0, 3'd0, 3'd5, 0, 2'd2, 0, 5'd1), 1, 1, 1, 1, 0, "R9 err ack");
        idle(1);
        // R10: back-to-back end-of-message strobes
        send(3'd0, mk_hdr(0, 3'd1, 3'd1, 0, 2'd1, 0, 5'd6), 0, 1, 0, 0, 0, "R10 b2b a");
        send(3'd3, mk_hdr(0, 3'd0, 3'd2, 0, 2'd2, 0, 5'd1), 0, 0, 0, 0, 0, "R10 b2b b");
        send(3'd3, mk_hdr(0, 3'd3, 3'd4, 0, 2'd0, 0, 5'd7), 0, 1, 1, 1, 1, "R10 b2b c");
        send(3'd1, mk_hdr(0, 3'd0, 3'd0, 0, 2'd0, 0, 5'd9), 0, 1, 1, 0, 0, "R10 b2b d");
        idle(1);
        // R11: input activity without end-of-message
        noise(12);
        idle(3);
        finish_run();
    end

endmodule